// File: doc/BRIEF.md
# Memory-Mapped GPIO Port with Edge-Event Interrupt

This block is a 32-pin general-purpose I/O port that sits behind a plain single-cycle register bus. Software sets, for each pin, whether it drives and whether it drives push-pull or open-drain. It writes a whole-word output latch and reads back a data word. In that word, output pins show the latch and input pins show the synchronized pad level.

Each pad input passes through a two-flop synchronizer. An edge detector compares the synchronized level with its value one cycle earlier. A per-pin select bit chooses whether only falling edges count or every change counts. Detected edges set sticky event bits. Software clears these bits by writing ones to them. A single interrupt line stays high while any event bit is pending and enabled in the mask register.

Pads are numbered 0..31 on the pin-side vectors. Inside every register, pin n occupies bit 31-n, so pin 0 is the most significant bit.

Top module: `gpio_evt_port`

## Requirements
- R1: After reset every register reads 0, no pad is driven (`pad_oe` = 0) and `irq` is 0.
- R2: Pin n (pad vector index n) maps to register bit 31-n in every register.
- R3: Register offset 0x00 holds the direction bits (1 = output). An output pin whose open-drain bit is 0 drives `pad_oe`=1 with `pad_out` equal to its latch bit. An input pin is never driven.
- R4: Offset 0x04 holds the open-drain bits. An output pin with open-drain bit 1 drives low (`pad_oe`=1, `pad_out`=0) when its latch bit is 0. It is released (`pad_oe`=0) when its latch bit is 1.
- R5: A read of offset 0x08 returns the latch bit for output pins and, for input pins, the pad level seen through two synchronizer flops.
- R6: Offset 0x14 holds the edge-select bits. With the bit at 0, both rising and falling pad edges set the pin's event bit at offset 0x0C. With the bit at 1, only falling edges set it and rising edges are ignored.
- R7: Writing offset 0x0C clears every event bit written as 1 and leaves bits written as 0 unchanged.
- R8: `irq` is high exactly when some bit is set in both the event register and the mask register (offset 0x10).
- R9: When a new edge and a clearing write hit the same event bit in the same cycle, the bit stays set.
- R10: Writes to offsets 0x00, 0x04, 0x08, 0x10 and 0x14 replace all 32 bits at once and read back unchanged. Any other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe; read data is valid in the same cycle |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, 0 when no read is requested |
| pad_in | input | 32 | Pad levels, index = pin number |
| pad_out | output | 32 | Pad output levels, index = pin number |
| pad_oe | output | 32 | Pad output enables, index = pin number |
| irq | output | 1 | Combined interrupt request |

## Verification
The port is tried with a mixed direction word so that one data read shows latch bits and sampled pad bits side by side. A single-pin drive exposes any mistake in the reversed bit order. Edge capture is tried with a rising and then a falling edge under each edge-select value, which tells the any-change mode from the falling-only mode. Two pending events cleared one at a time show that a write-one clear is per bit and not whole-register. The mask is set to the pending bit, then to an unrelated bit, to show that the interrupt needs the two to overlap. A clearing write timed onto the cycle a fresh edge lands tells event priority from clear priority.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;
  localparam int unsigned NPIN   = 32;
  localparam int unsigned ADDR_W = 5;

  typedef enum logic [ADDR_W-1:0] {
    OFF_DIR = 5'h00,
    OFF_ODR = 5'h04,
    OFF_DAT = 5'h08,
    OFF_EVT = 5'h0C,
    OFF_MSK = 5'h10,
    OFF_EDG = 5'h14
  } reg_off_e;

  // pin n <-> register bit NPIN-1-n
  function automatic logic [NPIN-1:0] pin_flip(input logic [NPIN-1:0] v);
    logic [NPIN-1:0] r;
    for (int i = 0; i < NPIN; i++) r[NPIN-1-i] = v[i];
    return r;
  endfunction

  // data read view: outputs show the latch, inputs show the sample
  function automatic logic [NPIN-1:0] data_view(input logic [NPIN-1:0] dir,
                                                input logic [NPIN-1:0] latch,
                                                input logic [NPIN-1:0] smp);
    return (dir & latch) | (~dir & smp);
  endfunction

  // edge select: 1 = falling only, 0 = any change
  function automatic logic [NPIN-1:0] edge_pick(input logic [NPIN-1:0] now,
                                                input logic [NPIN-1:0] prev,
                                                input logic [NPIN-1:0] fall_only);
    return (fall_only & prev & ~now) | (~fall_only & (prev ^ now));
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_edge.sv
module gpio_edge #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] smp,
  input  logic [W-1:0] fall_only,
  output logic [W-1:0] hit
);
  import gpio_evt_pkg::*;
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else prev_q <= smp;
  end

  assign hit = edge_pick(smp, prev_q, fall_only);
endmodule

// File: rtl/gpio_evt_bank.sv
module gpio_evt_bank #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] hit,
  input  logic [W-1:0] clr,
  output logic [W-1:0] ev
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ev <= '0;
    else ev <= (ev & ~clr) | hit;  // new edge beats clear
  end
endmodule

// File: rtl/gpio_evt_port.sv
module gpio_evt_port
  import gpio_evt_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPIN-1:0]   bus_wdata,
  output logic [NPIN-1:0]   bus_rdata,
  input  logic [NPIN-1:0]   pad_in,
  output logic [NPIN-1:0]   pad_out,
  output logic [NPIN-1:0]   pad_oe,
  output logic              irq
);
  localparam int unsigned W = NPIN;

  logic [W-1:0] dir_q, odr_q, dat_q, msk_q, edg_q;
  logic [W-1:0] ev_q, smp_q, edge_hit, evt_clr;
  logic         wr_dir, wr_odr, wr_dat, wr_evt, wr_msk, wr_edg;

  assign wr_dir = bus_wr && (bus_addr == OFF_DIR);
  assign wr_odr = bus_wr && (bus_addr == OFF_ODR);
  assign wr_dat = bus_wr && (bus_addr == OFF_DAT);
  assign wr_evt = bus_wr && (bus_addr == OFF_EVT);
  assign wr_msk = bus_wr && (bus_addr == OFF_MSK);
  assign wr_edg = bus_wr && (bus_addr == OFF_EDG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      odr_q <= '0;
      dat_q <= '0;
      msk_q <= '0;
      edg_q <= '0;
    end else begin
      if (wr_dir) dir_q <= bus_wdata;
      if (wr_odr) odr_q <= bus_wdata;
      if (wr_dat) dat_q <= bus_wdata;
      if (wr_msk) msk_q <= bus_wdata;
      if (wr_edg) edg_q <= bus_wdata;
    end
  end

  gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_flip(pad_in)), .q(smp_q)
  );

  gpio_edge #(.W(W)) i_edge (
    .clk(clk), .rst_n(rst_n), .smp(smp_q), .fall_only(edg_q), .hit(edge_hit)
  );

  assign evt_clr = wr_evt ? bus_wdata : '0;

  gpio_evt_bank #(.W(W)) i_evt (
    .clk(clk), .rst_n(rst_n), .hit(edge_hit), .clr(evt_clr), .ev(ev_q)
  );

  // pad drive, register-bit space then flipped to pin order
  logic [W-1:0] oe_bits, out_bits;
  assign oe_bits  = dir_q & (~odr_q | ~dat_q);
  assign out_bits = dat_q & ~odr_q;
  assign pad_oe   = pin_flip(oe_bits);
  assign pad_out  = pin_flip(out_bits);

  assign irq = |(ev_q & msk_q);

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        OFF_DIR: bus_rdata = dir_q;
        OFF_ODR: bus_rdata = odr_q;
        OFF_DAT: bus_rdata = data_view(dir_q, dat_q, smp_q);
        OFF_EVT: bus_rdata = ev_q;
        OFF_MSK: bus_rdata = msk_q;
        OFF_EDG: bus_rdata = edg_q;
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_evt_port_chk.sv
module gpio_evt_port_chk
  import gpio_evt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NPIN-1:0]   bus_wdata,
  input logic [NPIN-1:0]   pad_out,
  input logic [NPIN-1:0]   pad_oe,
  input logic              irq,
  input logic [NPIN-1:0]   ev_q,
  input logic [NPIN-1:0]   msk_q,
  input logic [NPIN-1:0]   odr_q,
  input logic [NPIN-1:0]   edg_q,
  input logic [NPIN-1:0]   smp_q,
  input logic [NPIN-1:0]   edge_hit
);
  // R4
  od_never_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & pad_out & pin_flip(odr_q)) == '0);

  // R6
  fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit & edg_q & smp_q) == '0);

  // R7
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFF_EVT) |=>
      ((ev_q & $past(bus_wdata) & ~$past(edge_hit)) == '0));

  // R9
  event_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_hit) |=> ((ev_q & $past(edge_hit)) == $past(edge_hit)));

  // R8
  irq_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ((ev_q & msk_q) != '0));

  // R8
  irq_low_when_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msk_q == '0) |-> !irq);
endmodule

bind gpio_evt_port gpio_evt_port_chk i_chk (.*);

// File: tb/test_gpio_evt_port.sv
module test_gpio_evt_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, pads = '0, pad_out, pad_oe;
  logic        irq;
  int          n_vec = 0, n_bad = 0;
  logic [31:0] rd;

  localparam logic [4:0] A_DIR = 5'h00, A_ODR = 5'h04, A_DAT = 5'h08,
                         A_EVT = 5'h0C, A_MSK = 5'h10, A_EDG = 5'h14;

  always #5 clk = ~clk;

  gpio_evt_port i_gpio_evt_port (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pads), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  // register bit owned by pin p
  function automatic logic [31:0] pbit(int p);
    return 32'h8000_0000 >> p;
  endfunction

  function automatic logic [31:0] to_regs(logic [31:0] v);
    logic [31:0] r = '0;
    for (int p = 0; p < 32; p++) if (v[p]) r |= pbit(p);
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rdreg(logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic clear_all();
    settle();
    wr(A_EVT, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    rdreg(A_DIR, rd); chk("R1 dir", rd, 0);
    rdreg(A_ODR, rd); chk("R1 odr", rd, 0);
    rdreg(A_DAT, rd); chk("R1 dat", rd, 0);
    rdreg(A_EVT, rd); chk("R1 evt", rd, 0);
    rdreg(A_MSK, rd); chk("R1 msk", rd, 0);
    rdreg(A_EDG, rd); chk("R1 edg", rd, 0);
    chk("R1 pad_oe", pad_oe, 0);
    chk("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_regs();
    wr(A_DIR, 32'hA5A5_0F0F); rdreg(A_DIR, rd); chk("R10 dir", rd, 32'hA5A5_0F0F);
    wr(A_ODR, 32'h0000_FFFF); rdreg(A_ODR, rd); chk("R10 odr", rd, 32'h0000_FFFF);
    wr(A_MSK, 32'h1234_0001); rdreg(A_MSK, rd); chk("R10 msk", rd, 32'h1234_0001);
    wr(A_EDG, 32'hF00F_000F); rdreg(A_EDG, rd); chk("R10 edg", rd, 32'hF00F_000F);
    rdreg(5'h18, rd); chk("R10 unmapped", rd, 0);
    wr(A_ODR, 0); wr(A_MSK, 0); wr(A_EDG, 0);
    wr(A_DIR, 32'hFFFF_FFFF);
    wr(A_DAT, 32'h1234_5678);
    rdreg(A_DAT, rd); chk("R10 dat all outputs", rd, 32'h1234_5678);
    @(negedge clk);
    chk("R3 push-pull oe", pad_oe, 32'hFFFF_FFFF);
    chk("R3 push-pull out", to_regs(pad_out), 32'h1234_5678);
    wr(A_DAT, 0); wr(A_DIR, 0);
  endtask

  task automatic t_pin_order();
    wr(A_DIR, pbit(3)); wr(A_DAT, pbit(3));
    @(negedge clk);
    chk("R2 oe pin3", pad_oe, 32'h0000_0008);
    chk("R2 out pin3", pad_out, 32'h0000_0008);
    wr(A_DIR, 0); @(negedge clk);
    chk("R3 input not driven", pad_oe, 0);
    wr(A_DAT, 0);
  endtask

  task automatic t_open_drain();
    wr(A_DIR, pbit(3)); wr(A_ODR, pbit(3)); wr(A_DAT, pbit(3));
    @(negedge clk);
    chk("R4 od released", pad_oe, 0);
    wr(A_DAT, 0); @(negedge clk);
    chk("R4 od drive low oe", pad_oe, 32'h0000_0008);
    chk("R4 od drive low out", pad_out, 0);
    wr(A_ODR, 0); wr(A_DIR, 0);
  endtask

  task automatic t_readback();
    wr(A_DIR, 32'hFFFF_0000);
    wr(A_DAT, 32'hAAAA_AAAA);
    pads = 32'h0F0F_3C3C;
    settle();
    rdreg(A_DAT, rd);
    chk("R5 mixed read", rd, (32'hAAAA_AAAA & 32'hFFFF_0000) |
                             (to_regs(32'h0F0F_3C3C) & 32'h0000_FFFF));
    pads = 0;
    wr(A_DIR, 0); wr(A_DAT, 0);
    clear_all();
  endtask

  task automatic t_any_edge();
    pads[5] = 1'b1; settle();
    rdreg(A_EVT, rd); chk("R6 any-edge rise", rd, pbit(5));
    wr(A_EVT, 32'hFFFF_FFFF);
    pads[5] = 1'b0; settle();
    rdreg(A_EVT, rd); chk("R6 any-edge fall", rd, pbit(5));
    wr(A_EVT, 32'hFFFF_FFFF);
  endtask

  task automatic t_fall_only();
    wr(A_EDG, pbit(7));
    pads[7] = 1'b1; settle();
    rdreg(A_EVT, rd); chk("R6 falling-only ignores rise", rd, 0);
    pads[7] = 1'b0; settle();
    rdreg(A_EVT, rd); chk("R6 falling-only fall", rd, pbit(7));
    wr(A_EVT, 32'hFFFF_FFFF); wr(A_EDG, 0);
  endtask

  task automatic t_w1c();
    pads[1] = 1'b1; pads[2] = 1'b1; settle();
    rdreg(A_EVT, rd); chk("R7 two pending", rd, pbit(1) | pbit(2));
    wr(A_EVT, pbit(1));
    rdreg(A_EVT, rd); chk("R7 clear one bit", rd, pbit(2));
    wr(A_EVT, 0);
    rdreg(A_EVT, rd); chk("R7 zero write no effect", rd, pbit(2));
  endtask

  task automatic t_irq();
    chk("R8 masked off", {31'b0, irq}, 0);
    wr(A_MSK, pbit(2)); @(negedge clk);
    chk("R8 pending and enabled", {31'b0, irq}, 1);
    wr(A_MSK, pbit(9)); @(negedge clk);
    chk("R8 mask elsewhere", {31'b0, irq}, 0);
    wr(A_MSK, pbit(2)); wr(A_EVT, 32'hFFFF_FFFF); @(negedge clk);
    chk("R8 cleared", {31'b0, irq}, 0);
    wr(A_MSK, 0);
    pads[1] = 1'b0; pads[2] = 1'b0;
    clear_all();
  endtask

  task automatic t_collide();
    pads[4] = 1'b1; settle();
    @(negedge clk); pads[4] = 1'b0;  // edge hit valid two edges later
    @(negedge clk); @(negedge clk);
    bus_wr = 1'b1; bus_addr = A_EVT; bus_wdata = pbit(4);
    @(posedge clk); #1 bus_wr = 1'b0;
    rdreg(A_EVT, rd); chk("R9 edge beats clear", rd, pbit(4));
    wr(A_EVT, pbit(4));
    rdreg(A_EVT, rd); chk("R9 later clear works", rd, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_pin_order();
    t_open_drain();
    t_readback();
    t_any_edge();
    t_fall_only();
    t_w1c();
    t_irq();
    t_collide();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule